// File: doc/BRIEF.md
# Serial Reflected CRC-8 Checker

This block accumulates the 8-bit checksum that protects device identifiers and data blocks on a single-wire sensor bus. The link layer feeds it one received or transmitted bit per clock, least significant bit of each byte first. The register is reflected: each step shifts right. When the feedback bit is set, the shifted value is XORed with the constant 0x8C. A byte-wide port can also advance the register by eight steps in one cycle. This suits data that is already assembled into bytes.

The register starts at zero and returns to zero on a clear. The caller runs the data bytes through the block, lowest byte first, and then the CRC byte that came with them. The block has no notion of framing, so the caller decides which bits or bytes to cover. A block that is intact leaves a residue of zero, and the zero flag reports this at once.

Top module: `crc8_serial_checker`

## Requirements
- R1: After reset the CRC register is 0x00 and the zero flag is 1.
- R2: A cycle with bitValid high and no higher-priority input computes the feedback bit as bitIn XOR the register's bit 0. The register then becomes itself shifted right by one, XORed with 0x8C when the feedback bit is 1. The new value appears on crcValue after that clock edge.
- R3: clear sets the register to 0x00 at the next edge. It takes priority over bitValid and byteValid in the same cycle, and both of those are then ignored.
- R4: In a cycle with clear, bitValid and byteValid all low, the register holds its value.
- R5: A cycle with byteValid high (and clear low) advances the register exactly as eight bit steps would, applied to byteIn bit 0 first through bit 7 last, in that single cycle.
- R6: When byteValid and bitValid are both high without clear, only the byte step is applied and the serial bit is ignored.
- R7: residueZero is 1 in exactly those cycles in which crcValue equals 0x00, with no added latency.
- R8: Starting from 0x00, any byte sequence followed by its own CRC byte leaves a residue of 0x00. This holds whether the sequence is fed bit by bit or byte by byte. A 64-bit identifier (seven bytes plus CRC, lowest byte first) is therefore valid exactly when the residue is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Restart the checksum at 0x00 |
| bitValid | input | 1 | Apply one serial step with bitIn |
| bitIn | input | 1 | Serial data bit |
| byteValid | input | 1 | Apply eight steps with byteIn |
| byteIn | input | 8 | Byte data, bit 0 consumed first |
| crcValue | output | 8 | Current CRC register |
| residueZero | output | 1 | High when crcValue is zero |

## Verification
Random mixes of clear, serial and byte strobes are applied and compared every cycle against a bench model. These mixes separate wrong priority (clear against steps, byte against bit) from wrong step arithmetic, because each error diverges the register differently. Serial runs with every bit 1 and every bit 0 exercise the feedback path with a set and a clear LSB on every step. Whole messages closed by their computed CRC byte, fed serially and as bytes, must end at zero. This catches a wrong bit order or a wrong polynomial that a single-step check could miss. Idle gaps between steps show whether the register holds its value.

// File: rtl/crc8_pkg.sv
package crc8_pkg;
  localparam int CRC_W = 8;
  localparam int DATA_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h8C;
  localparam logic [CRC_W-1:0] CRC_INIT = 8'h00;

  typedef struct packed {
    logic              clr;
    logic              stepBit;
    logic              stepByte;
    logic              bitVal;
    logic [DATA_W-1:0] byteVal;
  } crcCtrl_t;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] cur,
                                               input logic din,
                                               input logic [CRC_W-1:0] poly);
    logic fb;
    fb = din ^ cur[0];
    crcStep = (cur >> 1) ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/crc8_ctrl.sv
module crc8_ctrl
  import crc8_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clear,
  input  logic          bitValid,
  input  logic          bitIn,
  input  logic          byteValid,
  input  logic [DW-1:0] byteIn,
  output crcCtrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.bitVal  = bitIn;
    ctrl.byteVal = byteIn;
    if (clear) begin
      ctrl.clr = 1'b1;
    end else if (byteValid) begin
      ctrl.stepByte = 1'b1;
    end else if (bitValid) begin
      ctrl.stepBit = 1'b1;
    end
  end

  // R6: at most one operation is issued per cycle
  assert_one_op_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.clr, ctrl.stepBit, ctrl.stepByte}));
  // R3: clear suppresses both step kinds
  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    clear |-> (!ctrl.stepBit && !ctrl.stepByte));
  // R6: byte step wins over serial step
  assert_byte_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && byteValid && bitValid) |-> (ctrl.stepByte && !ctrl.stepBit));
endmodule

// File: rtl/crc8_datapath.sv
module crc8_datapath
  import crc8_pkg::*;
#(
  parameter int               CW   = CRC_W,
  parameter int               DW   = DATA_W,
  parameter logic [CW-1:0]    POLY = CRC_POLY,
  parameter logic [CW-1:0]    INIT = CRC_INIT
) (
  input  logic          clk,
  input  logic          rstN,
  input  crcCtrl_t      ctrl,
  output logic [CW-1:0] crcReg,
  output logic          isZero
);
  logic [CW-1:0] chain [0:DW];
  logic [CW-1:0] bitNext;
  logic [CW-1:0] crcNext;

  assign chain[0] = crcReg;
  for (genvar g = 0; g < DW; g++) begin : gByteStage
    assign chain[g+1] = crcStep(chain[g], ctrl.byteVal[g], POLY);
  end

  assign bitNext = crcStep(crcReg, ctrl.bitVal, POLY);

  always_comb begin
    crcNext = crcReg;
    if (ctrl.clr)           crcNext = INIT;
    else if (ctrl.stepByte) crcNext = chain[DW];
    else if (ctrl.stepBit)  crcNext = bitNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) crcReg <= INIT;
    else       crcReg <= crcNext;
  end

  assign isZero = (crcReg == '0);

  // R3: a clear lands the register on its start value
  assert_clear_init_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clr |=> (crcReg == INIT));
  // R4: no strobe leaves the register alone
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.clr && !ctrl.stepBit && !ctrl.stepByte) |=> $stable(crcReg));
  // R2: zero feedback brings a zero into the top bit
  assert_fb0_msb_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.stepBit && !(ctrl.bitVal ^ crcReg[0])) |=> (crcReg[CW-1] == 1'b0));
  // R2: set feedback brings the constant's top bit in
  assert_fb1_msb_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.stepBit && (ctrl.bitVal ^ crcReg[0])) |=> (crcReg[CW-1] == POLY[CW-1]));
endmodule

// File: rtl/crc8_serial_checker.sv
module crc8_serial_checker
  import crc8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              bitValid,
  input  logic              bitIn,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteIn,
  output logic [CRC_W-1:0]  crcValue,
  output logic              residueZero
);
  crcCtrl_t ctrl;

  crc8_ctrl #(.DW(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .clear(clear), .bitValid(bitValid),
    .bitIn(bitIn), .byteValid(byteValid), .byteIn(byteIn), .ctrl(ctrl)
  );

  crc8_datapath #(.CW(CRC_W), .DW(DATA_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .crcReg(crcValue), .isZero(residueZero)
  );

  // R7: the flag follows the register in the same cycle
  assert_flag_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    residueZero == (crcValue == '0));
endmodule

// File: tb/sim_crc8_serial_checker.sv
module sim_crc8_serial_checker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clear = 1'b0, bitValid = 1'b0, bitIn = 1'b0, byteValid = 1'b0;
  logic [7:0] byteIn = '0;
  logic [7:0] crcValue;
  logic residueZero;
  logic [7:0] model = 8'h00;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  crc8_serial_checker u0 (
    .clk(clk), .rstN(rstN), .clear(clear), .bitValid(bitValid), .bitIn(bitIn),
    .byteValid(byteValid), .byteIn(byteIn), .crcValue(crcValue), .residueZero(residueZero)
  );

  function automatic logic [7:0] refBit(input logic [7:0] c, input logic b);
    logic fb;
    fb = b ^ c[0];
    return (c >> 1) ^ (fb ? 8'h8C : 8'h00);
  endfunction

  function automatic logic [7:0] refByte(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = refBit(r, d[i]);
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    nChecks++;
    if (crcValue !== exp || residueZero !== (exp == 8'h00)) begin
      nFails++;
      $display("FAIL %s crc=%02h zero=%0b expected crc=%02h zero=%0b",
               req, crcValue, residueZero, exp, exp == 8'h00);
    end
  endtask

  // drive on falling edge, sample 2 ns after the following rising edge
  task automatic applyOp(input string req, input logic c, input logic bv, input logic bi,
                         input logic yv, input logic [7:0] yi);
    @(negedge clk);
    clear = c; bitValid = bv; bitIn = bi; byteValid = yv; byteIn = yi;
    if (c) model = 8'h00;
    else if (yv) model = refByte(model, yi);
    else if (bv) model = refBit(model, bi);
    @(posedge clk);
    #2;
    check(req, model);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] msg [0:7];
    logic [7:0] acc;
    void'($urandom(32'd1957));
    repeat (3) @(posedge clk);
    #2;
    check("R1", 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;
    check("R1", 8'h00);

    // directed: serial all ones then all zeros (R2), idle holds (R4)
    for (int i = 0; i < 12; i++) applyOp("R2", 0, 1, 1, 0, 8'h00);
    for (int i = 0; i < 12; i++) applyOp("R2", 0, 1, 0, 0, 8'h00);
    for (int i = 0; i < 5; i++) applyOp("R4", 0, 0, 1, 0, 8'hFF);
    // clear wins over both steps (R3)
    applyOp("R2", 0, 1, 1, 0, 8'h00);
    applyOp("R3", 1, 1, 1, 1, 8'hA5);
    // byte step vs eight bit steps (R5), byte wins over bit (R6)
    applyOp("R5", 0, 0, 0, 1, 8'h5A);
    applyOp("R6", 0, 1, 1, 1, 8'h3C);
    applyOp("R6", 0, 1, 0, 1, 8'hC3);

    // R8: identifier with appended CRC, serial then byte-wide
    for (int pass = 0; pass < 4; pass++) begin
      acc = 8'h00;
      for (int k = 0; k < 7; k++) begin
        msg[k] = 8'($urandom);
        acc = refByte(acc, msg[k]);
      end
      msg[7] = acc;
      applyOp("R3", 1, 0, 0, 0, 8'h00);
      for (int k = 0; k < 8; k++) begin
        for (int b = 0; b < 8; b++) begin
          if (pass[0]) applyOp("R8", 0, 1, msg[k][b], 0, 8'h00);
          else if (b == 0) applyOp("R8", 0, 0, 0, 1, msg[k]);
        end
      end
      nChecks++;
      if (crcValue !== 8'h00 || residueZero !== 1'b1) begin
        nFails++;
        $display("FAIL R8 residue crc=%02h zero=%0b expected crc=00 zero=1",
                 crcValue, residueZero);
      end
      // R7: one more bit breaks the zero residue in the flag too
      applyOp("R7", 0, 1, 1, 0, 8'h00);
    end

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = $urandom % 100;
      if (r < 5)       applyOp("R3", 1, $urandom % 2, $urandom % 2, $urandom % 2, 8'($urandom));
      else if (r < 25) applyOp("R5", 0, $urandom % 2, $urandom % 2, 1, 8'($urandom));
      else if (r < 80) applyOp("R2", 0, 1, $urandom % 2, 0, 8'($urandom));
      else             applyOp("R4", 0, 0, $urandom % 2, 0, 8'($urandom));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule